// File: doc/BRIEF.md
# Branch and Skip Decision Unit

This unit decides where a small microcontroller core goes next after a control-flow instruction, and how many cycles that instruction costs. The decode stage presents one operation with all of its operands and raises a valid strobe. One clock later the unit returns the next program counter, a flag that says whether the flow was redirected, and a cycle count. It handles sequential advance, short relative jumps, jumps through a pointer register, conditional branches on any status bit, and skips that step over the whole following instruction.

Status bits use a fixed order. C is bit 0, Z is bit 1, N is bit 2, V is bit 3, S is bit 4, H is bit 5, T is bit 6 and I is bit 7. Named branches such as equal, lower or same-or-higher are just a bit index plus a polarity. The decoder sends them as such, for example Z with polarity 1, C with polarity 1, or C with polarity 0. A skip advances the counter by two or three words, depending on whether the instruction being skipped is one or two words long. The decoder supplies that length as an input. All counter arithmetic wraps modulo the counter width.

Top module: `branch_skip_unit`

## Requirements
- R1: While reset is low, and after it is released until the first accepted operation, res_valid, taken, cycles and next_pc are all zero.
- R2: An operation sampled with op_valid high at a rising edge appears on the outputs after that edge, with res_valid high for exactly one cycle. If op_valid is low, res_valid falls and next_pc, taken and cycles keep their previous values.
- R3: Op code 0 (sequential), and the unused codes 6 and 7, give next_pc = pc + 1, taken = 0 and cycles = 1.
- R4: Op code 1 (relative jump) gives next_pc = pc + k + 1. Here k is the full 12-bit rel_off sign-extended. The result has taken = 1 and cycles = 2.
- R5: Op code 2 (pointer jump) gives next_pc = the low PC_W bits of z_ptr, with taken = 1 and cycles = 2.
- R6: Op code 3 (conditional branch) is taken when status bit sreg[cond_sel] equals want_set.
- R7: A taken branch gives next_pc = pc + k + 1, where k is rel_off[6:0] sign-extended and rel_off[11:7] is ignored, with cycles = 2. A branch that is not taken gives pc + 1 and cycles = 1.
- R8: When built with DERIVE_SIGN = 1, a branch on cond_sel = 4 tests N XOR V (bit 2 XOR bit 3) rather than the stored bit 4.
- R9: Op code 4 (compare skip) skips when cmp_a equals cmp_b.
- R10: Op code 5 (bit skip) skips when test_byte[bit_sel] equals want_set.
- R11: A skip that happens gives pc + 2 with cycles = 2 when next_two_word = 0, and pc + 3 with cycles = 3 when next_two_word = 1. A skip that does not happen gives pc + 1 and cycles = 1. The taken flag mirrors the skip decision.
- R12: Every next_pc computation wraps modulo 2^PC_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op | input | 3 | Operation code (0..5 used) |
| pc | input | PC_W | Address of the current instruction |
| sreg | input | 8 | Status bits C,Z,N,V,S,H,T,I at bits 0..7 |
| cond_sel | input | 3 | Status bit index for branches |
| want_set | input | 1 | Polarity: 1 tests for set, 0 for clear |
| rel_off | input | JMP_OFF_W | Relative offset; branches use the low BR_OFF_W bits |
| z_ptr | input | Z_W | Pointer register for pointer jumps |
| test_byte | input | DATA_W | Register or I/O byte for bit skips |
| bit_sel | input | log2(DATA_W) | Bit index into test_byte |
| cmp_a | input | DATA_W | First compare operand |
| cmp_b | input | DATA_W | Second compare operand |
| next_two_word | input | 1 | Following instruction occupies two words |
| res_valid | output | 1 | Result present |
| next_pc | output | PC_W | Address to fetch next |
| taken | output | 1 | Flow redirected or instruction skipped |
| cycles | output | 2 | Cycles used by the instruction |

## Verification
The bench builds the unit with PC_W = 10 and DERIVE_SIGN = 1. The narrow counter puts wrap-around within reach of small addresses near 1023, for jumps, sequential advance and three-word skips, and also for backward branches from address 2. The derived-sign variant lets one vector set the stored S bit against N XOR V, which shows which one the branch really tests. The 12-bit jump offset and the 16-bit pointer are both wider than the 10-bit counter, so truncation on both paths is covered as well.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

   localparam int SR_W      = 8;
   localparam int SR_SEL_W  = 3;
   localparam int CYC_W     = 2;

   // status bit positions the decision depends on
   localparam int FLG_N     = 2;
   localparam int FLG_V     = 3;
   localparam int FLG_S     = 4;

   // operation codes
   localparam logic [2:0] OP_SEQ   = 3'd0;
   localparam logic [2:0] OP_JREL  = 3'd1;
   localparam logic [2:0] OP_JIND  = 3'd2;
   localparam logic [2:0] OP_BRC   = 3'd3;
   localparam logic [2:0] OP_SKEQ  = 3'd4;
   localparam logic [2:0] OP_SKBIT = 3'd5;

   localparam logic [CYC_W-1:0] CYC_1 = 2'd1;
   localparam logic [CYC_W-1:0] CYC_2 = 2'd2;
   localparam logic [CYC_W-1:0] CYC_3 = 2'd3;

   typedef struct packed {
      logic             taken;
      logic [CYC_W-1:0] cyc;
   } decision_t;

endpackage

// File: rtl/bsu_flag_test.sv
module bsu_flag_test
   import bsu_pkg::*;
#(
   parameter bit DERIVE_SIGN = 1'b0
)(
   input  logic [SR_W-1:0]     sreg,
   input  logic [SR_SEL_W-1:0] cond_sel,
   input  logic                want_set,
   output logic                hit
);

   logic stored_bit;
   logic tested_bit;

   assign stored_bit = sreg[cond_sel];

   generate
      if (DERIVE_SIGN) begin : g_derived_sign
         logic sign_now;
         assign sign_now   = sreg[FLG_N] ^ sreg[FLG_V];
         assign tested_bit = (cond_sel == SR_SEL_W'(FLG_S)) ? sign_now : stored_bit;
      end else begin : g_stored_sign
         assign tested_bit = stored_bit;
      end
   endgenerate

   assign hit = (tested_bit == want_set);

endmodule

// File: rtl/bsu_skip_test.sv
module bsu_skip_test #(
   parameter int DATA_W = 8,
   localparam int SEL_W = $clog2(DATA_W)
)(
   input  logic              bit_mode,
   input  logic [DATA_W-1:0] cmp_a,
   input  logic [DATA_W-1:0] cmp_b,
   input  logic [DATA_W-1:0] test_byte,
   input  logic [SEL_W-1:0]  bit_sel,
   input  logic              want_set,
   output logic              hit
);

   logic eq_hit;
   logic bit_hit;

   assign eq_hit  = (cmp_a == cmp_b);
   assign bit_hit = (test_byte[bit_sel] == want_set);
   assign hit     = bit_mode ? bit_hit : eq_hit;

endmodule

// File: rtl/bsu_rel_target.sv
module bsu_rel_target #(
   parameter int PC_W  = 16,
   parameter int OFF_W = 12
)(
   input  logic [PC_W-1:0]  pc,
   input  logic [OFF_W-1:0] off,
   output logic [PC_W-1:0]  target
);

   logic [PC_W-1:0] off_ext;

   generate
      if (OFF_W >= PC_W) begin : g_trunc
         assign off_ext = off[PC_W-1:0];
      end else begin : g_sext
         assign off_ext = {{(PC_W-OFF_W){off[OFF_W-1]}}, off};
      end
   endgenerate

   assign target = pc + off_ext + PC_W'(1);

endmodule

// File: rtl/branch_skip_unit.sv
module branch_skip_unit
   import bsu_pkg::*;
#(
   parameter int PC_W        = 16,
   parameter int JMP_OFF_W   = 12,
   parameter int BR_OFF_W    = 7,
   parameter int Z_W         = 16,
   parameter int DATA_W      = 8,
   parameter bit DERIVE_SIGN = 1'b0,
   localparam int BSEL_W     = $clog2(DATA_W)
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 op_valid,
   input  logic [2:0]           op,
   input  logic [PC_W-1:0]      pc,
   input  logic [SR_W-1:0]      sreg,
   input  logic [SR_SEL_W-1:0]  cond_sel,
   input  logic                 want_set,
   input  logic [JMP_OFF_W-1:0] rel_off,
   input  logic [Z_W-1:0]       z_ptr,
   input  logic [DATA_W-1:0]    test_byte,
   input  logic [BSEL_W-1:0]    bit_sel,
   input  logic [DATA_W-1:0]    cmp_a,
   input  logic [DATA_W-1:0]    cmp_b,
   input  logic                 next_two_word,
   output logic                 res_valid,
   output logic [PC_W-1:0]      next_pc,
   output logic                 taken,
   output logic [CYC_W-1:0]     cycles
);

   // elaboration-time parameter checks
   generate
      if (PC_W < 4 || PC_W > 24) begin : g_bad_pc_w
         $error("branch_skip_unit: PC_W out of range");
      end
      if (BR_OFF_W < 2 || BR_OFF_W >= JMP_OFF_W) begin : g_bad_off_w
         $error("branch_skip_unit: BR_OFF_W must be at least 2 and below JMP_OFF_W");
      end
      if (DATA_W < 2 || (1 << BSEL_W) != DATA_W) begin : g_bad_data_w
         $error("branch_skip_unit: DATA_W must be a power of two");
      end
   endgenerate

   logic [PC_W-1:0] pc_seq;
   logic [PC_W-1:0] pc_skip1;
   logic [PC_W-1:0] pc_skip2;
   logic [PC_W-1:0] pc_jrel;
   logic [PC_W-1:0] pc_brc;
   logic [PC_W-1:0] pc_zptr;
   logic            brc_hit;
   logic            skip_hit;

   assign pc_seq   = pc + PC_W'(1);
   assign pc_skip1 = pc + PC_W'(2);
   assign pc_skip2 = pc + PC_W'(3);

   generate
      if (Z_W >= PC_W) begin : g_z_trunc
         assign pc_zptr = z_ptr[PC_W-1:0];
      end else begin : g_z_zext
         assign pc_zptr = {{(PC_W-Z_W){1'b0}}, z_ptr};
      end
   endgenerate

   bsu_rel_target #(.PC_W(PC_W), .OFF_W(JMP_OFF_W)) u_jmp_target (
      .pc     (pc),
      .off    (rel_off),
      .target (pc_jrel)
   );

   bsu_rel_target #(.PC_W(PC_W), .OFF_W(BR_OFF_W)) u_brc_target (
      .pc     (pc),
      .off    (rel_off[BR_OFF_W-1:0]),
      .target (pc_brc)
   );

   bsu_flag_test #(.DERIVE_SIGN(DERIVE_SIGN)) u_flag_test (
      .sreg     (sreg),
      .cond_sel (cond_sel),
      .want_set (want_set),
      .hit      (brc_hit)
   );

   bsu_skip_test #(.DATA_W(DATA_W)) u_skip_test (
      .bit_mode  (op == OP_SKBIT),
      .cmp_a     (cmp_a),
      .cmp_b     (cmp_b),
      .test_byte (test_byte),
      .bit_sel   (bit_sel),
      .want_set  (want_set),
      .hit       (skip_hit)
   );

   decision_t       dec;
   logic [PC_W-1:0] pc_d;

   always_comb begin
      dec.taken = 1'b0;
      dec.cyc   = CYC_1;
      pc_d      = pc_seq;
      case (op)
         OP_JREL: begin
            dec.taken = 1'b1;
            dec.cyc   = CYC_2;
            pc_d      = pc_jrel;
         end
         OP_JIND: begin
            dec.taken = 1'b1;
            dec.cyc   = CYC_2;
            pc_d      = pc_zptr;
         end
         OP_BRC: begin
            if (brc_hit) begin
               dec.taken = 1'b1;
               dec.cyc   = CYC_2;
               pc_d      = pc_brc;
            end
         end
         OP_SKEQ, OP_SKBIT: begin
            if (skip_hit) begin
               dec.taken = 1'b1;
               dec.cyc   = next_two_word ? CYC_3 : CYC_2;
               pc_d      = next_two_word ? pc_skip2 : pc_skip1;
            end
         end
         default: begin
            dec.taken = 1'b0;
            dec.cyc   = CYC_1;
            pc_d      = pc_seq;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         next_pc   <= '0;
         taken     <= 1'b0;
         cycles    <= '0;
      end else begin
         res_valid <= op_valid;
         if (op_valid) begin
            next_pc <= pc_d;
            taken   <= dec.taken;
            cycles  <= dec.cyc;
         end
      end
   end

endmodule

// File: rtl/bsu_checker.sv
module bsu_checker
   import bsu_pkg::*;
#(
   parameter int PC_W   = 16,
   parameter int Z_W    = 16,
   parameter int DATA_W = 8
)(
   input logic                clk,
   input logic                rst_n,
   input logic                op_valid,
   input logic [2:0]          op,
   input logic [PC_W-1:0]     pc,
   input logic [Z_W-1:0]      z_ptr,
   input logic [DATA_W-1:0]   cmp_a,
   input logic [DATA_W-1:0]   cmp_b,
   input logic                next_two_word,
   input logic                res_valid,
   input logic [PC_W-1:0]     next_pc,
   input logic                taken,
   input logic [CYC_W-1:0]    cycles
);

   a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> res_valid);

   a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> !res_valid);

   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> ($stable(next_pc) && $stable(taken) && $stable(cycles)));

   a_r3_seq: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op == OP_SEQ) |=>
         (next_pc == PC_W'($past(pc) + PC_W'(1)) && !taken && cycles == CYC_1));

   a_r5_pointer: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op == OP_JIND) |=>
         (next_pc == PC_W'($past(z_ptr)) && taken && cycles == CYC_2));

   a_r7_not_taken_one: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !taken) |-> (cycles == CYC_1));

   a_r11_taken_cost: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && taken) |-> (cycles == CYC_2 || cycles == CYC_3));

   a_r11_two_word_skip: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op == OP_SKEQ && cmp_a == cmp_b && next_two_word) |=>
         (next_pc == PC_W'($past(pc) + PC_W'(3)) && cycles == CYC_3));

endmodule

bind branch_skip_unit bsu_checker #(.PC_W(PC_W), .Z_W(Z_W), .DATA_W(DATA_W)) u_bsu_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .op_valid      (op_valid),
   .op            (op),
   .pc            (pc),
   .z_ptr         (z_ptr),
   .cmp_a         (cmp_a),
   .cmp_b         (cmp_b),
   .next_two_word (next_two_word),
   .res_valid     (res_valid),
   .next_pc       (next_pc),
   .taken         (taken),
   .cycles        (cycles)
);

// File: tb/test_branch_skip_unit.sv
`timescale 1ns/1ps
module test_branch_skip_unit;

   localparam int PC_W = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [2:0]  op = '0;
   logic [9:0]  pc = '0;
   logic [7:0]  sreg = '0;
   logic [2:0]  cond_sel = '0;
   logic        want_set = 1'b0;
   logic [11:0] rel_off = '0;
   logic [15:0] z_ptr = '0;
   logic [7:0]  test_byte = '0;
   logic [2:0]  bit_sel = '0;
   logic [7:0]  cmp_a = '0;
   logic [7:0]  cmp_b = '0;
   logic        next_two_word = 1'b0;
   logic        res_valid;
   logic [9:0]  next_pc;
   logic        taken;
   logic [1:0]  cycles;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   branch_skip_unit #(.PC_W(PC_W), .DERIVE_SIGN(1'b1)) i_branch_skip_unit (
      .clk, .rst_n, .op_valid, .op, .pc, .sreg, .cond_sel, .want_set,
      .rel_off, .z_ptr, .test_byte, .bit_sel, .cmp_a, .cmp_b,
      .next_two_word, .res_valid, .next_pc, .taken, .cycles
   );

   typedef struct packed {
      logic [2:0]  op;
      logic [9:0]  pc;
      logic [7:0]  sreg;
      logic [2:0]  sel;
      logic        want;
      logic [11:0] off;
      logic [7:0]  tb;
      logic [2:0]  bs;
      logic [7:0]  a;
      logic [7:0]  b;
      logic        two;
      logic [15:0] z;
      logic [9:0]  epc;
      logic        et;
      logic [1:0]  ec;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 22;
   localparam vec_t VECS [NV] = '{
      '{3'd0, 10'd100,  8'h00, 3'd0, 1'b0, 12'h000, 8'h00, 3'd0, 8'd0, 8'd0, 1'b0, 16'h0000, 10'd101,  1'b0, 2'd1, 8'd3},  // R3
      '{3'd1, 10'd100,  8'h00, 3'd0, 1'b0, 12'h010, 8'h00, 3'd0, 8'd0, 8'd0, 1'b0, 16'h0000, 10'd117,  1'b1, 2'd2, 8'd4},  // R4
      '{3'd1, 10'd100,  8'h00, 3'd0, 1'b0, 12'hFF0, 8'h00, 3'd0, 8'd0, 8'd0, 1'b0, 16'h0000, 10'd85,   1'b1, 2'd2, 8'd4},  // R4
      '{3'd2, 10'd100,  8'h00, 3'd0, 1'b0, 12'h000, 8'h00, 3'd0, 8'd0, 8'd0, 1'b0, 16'h1234, 10'd564,  1'b1, 2'd2, 8'd5},  // R5
      '{3'd3, 10'd200,  8'h02, 3'd1, 1'b1, 12'h005, 8'h00, 3'd0, 8'd0, 8'd0, 1'b0, 16'h0000, 10'd206,  1'b1, 2'd2, 8'd6},  // R6
      '{3'd3, 10'd200,  8'h02, 3'd1, 1'b0, 12'h005, 8'h00, 3'd0, 8'd0, 8'd0, 1'b0, 16'h0000, 10'd201,  1'b0, 2'd1, 8'd7},  // R7
      '{3'd3, 10'd200,  8'h00, 3'd0, 1'b0, 12'h07F, 8'h00, 3'd0, 8'd0, 8'd0, 1'b0, 16'h0000, 10'd200,  1'b1, 2'd2, 8'd7},  // R7
      '{3'd3, 10'd200,  8'h01, 3'd0, 1'b1, 12'hF85, 8'h00, 3'd0, 8'd0, 8'd0, 1'b0, 16'h0000, 10'd206,  1'b1, 2'd2, 8'd7},  // R7
      '{3'd3, 10'd200,  8'h04, 3'd4, 1'b1, 12'h003, 8'h00, 3'd0, 8'd0, 8'd0, 1'b0, 16'h0000, 10'd204,  1'b1, 2'd2, 8'd8},  // R8
      '{3'd3, 10'd200,  8'h1C, 3'd4, 1'b1, 12'h003, 8'h00, 3'd0, 8'd0, 8'd0, 1'b0, 16'h0000, 10'd201,  1'b0, 2'd1, 8'd8},  // R8
      '{3'd4, 10'd300,  8'h00, 3'd0, 1'b0, 12'h000, 8'h00, 3'd0, 8'd5, 8'd5, 1'b0, 16'h0000, 10'd302,  1'b1, 2'd2, 8'd9},  // R9
      '{3'd4, 10'd300,  8'h00, 3'd0, 1'b0, 12'h000, 8'h00, 3'd0, 8'd5, 8'd5, 1'b1, 16'h0000, 10'd303,  1'b1, 2'd3, 8'd11}, // R11
      '{3'd4, 10'd300,  8'h00, 3'd0, 1'b0, 12'h000, 8'h00, 3'd0, 8'd5, 8'd6, 1'b1, 16'h0000, 10'd301,  1'b0, 2'd1, 8'd11}, // R11
      '{3'd5, 10'd400,  8'h00, 3'd0, 1'b1, 12'h000, 8'h80, 3'd7, 8'd0, 8'd0, 1'b0, 16'h0000, 10'd402,  1'b1, 2'd2, 8'd10}, // R10
      '{3'd5, 10'd400,  8'h00, 3'd0, 1'b0, 12'h000, 8'h80, 3'd7, 8'd0, 8'd0, 1'b0, 16'h0000, 10'd401,  1'b0, 2'd1, 8'd10}, // R10
      '{3'd5, 10'd400,  8'h00, 3'd0, 1'b0, 12'h000, 8'h00, 3'd3, 8'd1, 8'd2, 1'b1, 16'h0000, 10'd403,  1'b1, 2'd3, 8'd10}, // R10
      '{3'd1, 10'd1020, 8'h00, 3'd0, 1'b0, 12'h010, 8'h00, 3'd0, 8'd0, 8'd0, 1'b0, 16'h0000, 10'd13,   1'b1, 2'd2, 8'd12}, // R12
      '{3'd0, 10'd1023, 8'h00, 3'd0, 1'b0, 12'h000, 8'h00, 3'd0, 8'd0, 8'd0, 1'b0, 16'h0000, 10'd0,    1'b0, 2'd1, 8'd12}, // R12
      '{3'd4, 10'd1022, 8'h00, 3'd0, 1'b0, 12'h000, 8'h00, 3'd0, 8'd9, 8'd9, 1'b1, 16'h0000, 10'd1,    1'b1, 2'd3, 8'd12}, // R12
      '{3'd3, 10'd2,    8'h40, 3'd6, 1'b1, 12'h07A, 8'h00, 3'd0, 8'd0, 8'd0, 1'b0, 16'h0000, 10'd1021, 1'b1, 2'd2, 8'd12}, // R12
      '{3'd6, 10'd50,   8'hFF, 3'd7, 1'b1, 12'h123, 8'hFF, 3'd0, 8'd3, 8'd3, 1'b1, 16'h00AA, 10'd51,   1'b0, 2'd1, 8'd3},  // R3
      '{3'd3, 10'd10,   8'h80, 3'd7, 1'b1, 12'h000, 8'h00, 3'd0, 8'd0, 8'd0, 1'b0, 16'h0000, 10'd11,   1'b1, 2'd2, 8'd6}   // R6
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      op = v.op; pc = v.pc; sreg = v.sreg; cond_sel = v.sel; want_set = v.want;
      rel_off = v.off; test_byte = v.tb; bit_sel = v.bs; cmp_a = v.a; cmp_b = v.b;
      next_two_word = v.two; z_ptr = v.z;
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 res_valid", 32'(res_valid), 0);
      chk("R1 next_pc", 32'(next_pc), 0);
      chk("R1 taken", 32'(taken), 0);
      chk("R1 cycles", 32'(cycles), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", 32'({res_valid, taken, cycles, next_pc}), 0);

      for (int i = 0; i < NV; i++) begin
         drive(VECS[i]);
         op_valid = 1'b1;
         @(negedge clk);
         chk($sformatf("R%0d vec%0d valid", VECS[i].req, i), 32'(res_valid), 1);
         chk($sformatf("R%0d vec%0d next_pc", VECS[i].req, i), 32'(next_pc), 32'(VECS[i].epc));
         chk($sformatf("R%0d vec%0d taken", VECS[i].req, i), 32'(taken), 32'(VECS[i].et));
         chk($sformatf("R%0d vec%0d cycles", VECS[i].req, i), 32'(cycles), 32'(VECS[i].ec));
      end

      // R2: idle cycles hold the last result, with the valid strobe low
      drive(VECS[1]);
      op_valid = 1'b0;
      @(negedge clk);
      chk("R2 idle valid", 32'(res_valid), 0);
      chk("R2 idle next_pc", 32'(next_pc), 11);
      chk("R2 idle taken", 32'(taken), 1);
      chk("R2 idle cycles", 32'(cycles), 2);
      @(negedge clk);
      chk("R2 idle second cycle", 32'(next_pc), 11);

      // R2: back-to-back operations each give a fresh result
      drive(VECS[0]);
      op_valid = 1'b1;
      @(negedge clk);
      drive(VECS[11]);
      @(negedge clk);
      chk("R2 back-to-back next_pc", 32'(next_pc), 303);
      chk("R2 back-to-back valid", 32'(res_valid), 1);
      op_valid = 1'b0;

      // R7: upper offset bits ignored by a branch, all-ones upper field
      drive(VECS[4]);
      rel_off = 12'hF85;
      op_valid = 1'b1;
      @(negedge clk);
      chk("R7 upper bits ignored", 32'(next_pc), 206);
      op_valid = 1'b0;

      // R1: reset in mid-run clears everything
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 mid-run reset", 32'({res_valid, taken, cycles, next_pc}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      finish_run();
   end

endmodule